// File: doc/BRIEF.md
# Single-cycle 8-bit processor core

This block is a small Harvard-style processor that completes one 32-bit instruction on every rising clock edge. Programs live in a 256-word instruction memory, and all data lives in a single 256-byte store that serves at once as register file and data memory. An arithmetic instruction names two source bytes and one destination byte by full 8-bit address. An immediate instruction replaces the second source with a literal. A load instruction drops a literal byte anywhere in the store. Branches add an unsigned offset to the program counter, either always or when a chosen status flag is set.

The core has two phases, chosen by the `start` input. While `start` is low the core executes nothing, holds the program counter at zero and accepts instruction-memory writes through a simple write port. Once `start` is high the core fetches from address 00h and runs, and instruction-memory writes are refused. The last ALU result, the four status flags and the program counter are brought out for observation.

Instruction layout: opcode in bits [31:24], field F1 in [23:16], field F2 in [15:8], field F3 in [7:0]. Opcode bits [7:5] give the ALU operation, bit 2 selects the immediate form, bits [1:0] give the class, and bits [4:3] pick the tested flag of a conditional branch.

Top module: `sc8_core`

## Requirements
- R1: After reset, `pc`, `flags` and `alu_res` are 0, and every byte of the data store reads 0.
- R2: A register-form opcode (class bits 00, bit 2 clear) writes store[F3] = store[F1] op store[F2] and shows the result on `alu_res` one edge later. The codes are 40h add, C0h subtract, 00h AND, 20h OR and E0h set-less-than.
- R3: An immediate opcode (the register opcode plus 04h: 44h, C4h, 04h, 24h, E4h) uses F2 as a literal right operand and writes store[F3]. For subtract and set-less-than the stored byte is the left operand (store[F1] - F2, store[F1] < F2).
- R4: Set-less-than compares as signed two's complement values and yields 01h or 00h.
- R5: Every add, subtract, AND, OR or set-less-than updates `flags` with bit 0 Zero (result 00h), bit 1 Negative (result bit 7), bit 2 Positive (neither of the other two), bit 3 Overflow (signed overflow of add or subtract, else 0). At most one of bits 0 to 2 is ever set.
- R6: Load (opcode 05h) writes F1 to store[F2] and ignores F3. It leaves `flags` and `alu_res` unchanged.
- R7: Conditional branches are 02h (Zero), 0Ah (Negative), 12h (Positive) and 1Ah (Overflow). When the tested flag is set, the next `pc` is pc + F1 + 1. Otherwise, as after any non-branch instruction, it is pc + 1.
- R8: Opcode 03h always branches to pc + F1 + 1. F1 is an unsigned offset and all `pc` arithmetic wraps modulo 256.
- R9: While `start` is low, `pc` is held at 0 and no instruction changes the store, `flags` or `alu_res`. A write with `imem_wr` high stores `imem_data` at `imem_addr`. The first edge with `start` high executes the word at address 00h.
- R10: While `start` is high, `imem_wr` has no effect on instruction memory.
- R11: An opcode whose class bits are 00 but whose ALU code is 100 or 011 (for example 80h) changes nothing except advancing `pc` by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High runs the program; low halts and allows program loading |
| imem_wr | input | 1 | Instruction-memory write strobe, honoured only while halted |
| imem_addr | input | 8 | Instruction-memory write address |
| imem_data | input | 32 | Instruction word to write |
| alu_res | output | 8 | Result of the most recent ALU instruction |
| flags | output | 4 | Status flags: bit 0 Zero, 1 Negative, 2 Positive, 3 Overflow |
| pc | output | 8 | Program counter; address of the next instruction |

## Verification
The embedded properties check several rules on every cycle. A halted core always returns `pc` to zero. A load or an unknown ALU code leaves the result and the flags untouched. A non-taken instruction advances `pc` by exactly one. Zero, Negative and Positive are never set together. The scenarios must show the rest: the arithmetic values themselves, signed comparison, overflow on a carry into bit 7, the operand order of immediate subtract, taken and non-taken branches with wrap-around past FFh, and a refused program write while running, observed later by executing the unchanged word.

// File: rtl/sc8_pkg.sv
package sc8_pkg;
   localparam int NFLAG = 4;
   localparam int FLG_Z = 0;
   localparam int FLG_N = 1;
   localparam int FLG_P = 2;
   localparam int FLG_V = 3;

   localparam logic [2:0] AOP_AND = 3'b000;
   localparam logic [2:0] AOP_OR  = 3'b001;
   localparam logic [2:0] AOP_ADD = 3'b010;
   localparam logic [2:0] AOP_SUB = 3'b110;
   localparam logic [2:0] AOP_SLT = 3'b111;

   typedef enum logic [1:0] {
      KIND_ALU  = 2'b00,
      KIND_LOAD = 2'b01,
      KIND_CBR  = 2'b10,
      KIND_UBR  = 2'b11
   } kind_e;

   typedef struct packed {
      logic       alu_en;
      logic       use_imm;
      logic       st_load;
      logic       br_taken;
      logic [2:0] aluop;
   } ctrl_t;
endpackage

// File: rtl/sc8_decode.sv
module sc8_decode
   import sc8_pkg::*;
(
   input  logic [7:0]       opc,
   input  logic [NFLAG-1:0] flags,
   output ctrl_t            ctrl
);
   kind_e kind;
   logic  op_ok;

   always_comb begin
      kind = kind_e'(opc[1:0]);
      unique case (opc[7:5])
         AOP_AND, AOP_OR, AOP_ADD, AOP_SUB, AOP_SLT: op_ok = 1'b1;
         default:                                    op_ok = 1'b0;
      endcase
      ctrl.aluop    = opc[7:5];
      ctrl.use_imm  = opc[2];
      ctrl.alu_en   = (kind == KIND_ALU) && op_ok;
      ctrl.st_load  = (kind == KIND_LOAD);
      ctrl.br_taken = (kind == KIND_UBR) ||
                      ((kind == KIND_CBR) && flags[opc[4:3]]);
   end
endmodule

// File: rtl/sc8_alu.sv
module sc8_alu
   import sc8_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit SLT_SIGNED = 1'b1
)(
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   input  logic [2:0]       op,
   output logic [DW-1:0]    y,
   output logic [NFLAG-1:0] fl
);
   localparam int MSB = DW - 1;

   logic          lt;
   logic [DW-1:0] sum;
   logic [DW-1:0] dif;
   logic          ovf;

   generate
      if (SLT_SIGNED) begin : g_slt_signed
         assign lt = $signed(a) < $signed(b);
      end else begin : g_slt_unsigned
         assign lt = a < b;
      end
   endgenerate

   assign sum = a + b;
   assign dif = a - b;

   always_comb begin
      ovf = 1'b0;
      unique case (op)
         AOP_ADD: begin
            y   = sum;
            ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
         end
         AOP_SUB: begin
            y   = dif;
            ovf = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
         end
         AOP_AND: y = a & b;
         AOP_OR:  y = a | b;
         AOP_SLT: y = {{(DW-1){1'b0}}, lt};
         default: y = '0;
      endcase
      fl        = '0;
      fl[FLG_Z] = (y == '0);
      fl[FLG_N] = y[MSB];
      fl[FLG_P] = (y != '0) && !y[MSB];
      fl[FLG_V] = ovf;
   end
endmodule

// File: rtl/sc8_store.sv
module sc8_store #(
   parameter int DW             = 8,
   parameter int AW             = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_a,
   output logic [DW-1:0] rdata_b
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (we && rst_n) mem[waddr] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/sc8_imem.sv
module sc8_imem #(
   parameter int IW = 32,
   parameter int AW = 8
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [IW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [IW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [IW-1:0] mem [DEPTH];

   assign rdata = mem[raddr];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
endmodule

// File: rtl/sc8_core.sv
module sc8_core
   import sc8_pkg::*;
#(
   parameter int DW             = 8,
   parameter int AW             = 8,
   parameter bit SLT_SIGNED     = 1'b1,
   parameter bit CLEAR_ON_RESET = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              imem_wr,
   input  logic [AW-1:0]     imem_addr,
   input  logic [4*DW-1:0]   imem_data,
   output logic [DW-1:0]     alu_res,
   output logic [NFLAG-1:0]  flags,
   output logic [AW-1:0]     pc
);
   localparam int IW = 4 * DW;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("sc8_core: fields are byte coded, DW must be 8");
      end
      if (AW != DW) begin : g_bad_aw
         $error("sc8_core: address fields are DW wide, AW must equal DW");
      end
   endgenerate

   logic [AW-1:0]    pc_q;
   logic [DW-1:0]    res_q;
   logic [NFLAG-1:0] flags_q;
   logic [IW-1:0]    instr;
   logic [7:0]       opc;
   logic [DW-1:0]    f1, f2, f3;
   ctrl_t            ctrl;
   logic [DW-1:0]    op_a, mem_b, alu_b, alu_y;
   logic [NFLAG-1:0] alu_fl;
   logic             st_we;
   logic [AW-1:0]    st_waddr;
   logic [DW-1:0]    st_wdata;

   assign opc = instr[4*DW-1 -: 8];
   assign f1  = instr[3*DW-1 -: DW];
   assign f2  = instr[2*DW-1 -: DW];
   assign f3  = instr[DW-1:0];

   sc8_imem #(.IW(IW), .AW(AW)) u_imem (
      .clk   (clk),
      .we    (imem_wr && !start),
      .waddr (imem_addr),
      .wdata (imem_data),
      .raddr (pc_q),
      .rdata (instr)
   );

   sc8_decode u_dec (
      .opc   (opc),
      .flags (flags_q),
      .ctrl  (ctrl)
   );

   assign st_we    = start && (ctrl.alu_en || ctrl.st_load);
   assign st_waddr = ctrl.st_load ? AW'(f2) : AW'(f3);
   assign st_wdata = ctrl.st_load ? f1 : alu_y;

   sc8_store #(.DW(DW), .AW(AW), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_we),
      .waddr   (st_waddr),
      .wdata   (st_wdata),
      .raddr_a (AW'(f1)),
      .raddr_b (AW'(f2)),
      .rdata_a (op_a),
      .rdata_b (mem_b)
   );

   assign alu_b = ctrl.use_imm ? f2 : mem_b;

   sc8_alu #(.DW(DW), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .a  (op_a),
      .b  (alu_b),
      .op (ctrl.aluop),
      .y  (alu_y),
      .fl (alu_fl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (!start) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_q + AW'(1) + (ctrl.br_taken ? AW'(f1) : AW'(0));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_q <= '0;
      end else if (start && ctrl.alu_en) begin
         res_q   <= alu_y;
         flags_q <= alu_fl;
      end
   end

   assign pc      = pc_q;
   assign alu_res = res_q;
   assign flags   = flags_q;

   // R9: a halted core parks the program counter at zero
   p_idle_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> pc_q == '0);

   // R6: a load touches neither the flags nor the shown result
   p_load_keeps_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start && ctrl.st_load |=> $stable(flags_q) && $stable(res_q));

   // R7: anything that does not branch advances by exactly one
   p_step_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start && !ctrl.br_taken |=> pc_q == $past(pc_q) + AW'(1));

   // R5: Zero, Negative and Positive are mutually exclusive
   p_nzp_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags_q[FLG_P:FLG_Z]));

   // R11: an instruction without a valid ALU operation leaves result and flags
   p_no_alu_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start && !ctrl.alu_en |=> $stable(res_q) && $stable(flags_q));
endmodule

// File: tb/tb_sc8_core.sv
`timescale 1ns/1ps
module tb_sc8_core;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        imem_wr;
   logic [7:0]  imem_addr;
   logic [31:0] imem_data;
   logic [7:0]  alu_res;
   logic [3:0]  flags;
   logic [7:0]  pc;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   sc8_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .imem_wr   (imem_wr),
      .imem_addr (imem_addr),
      .imem_data (imem_data),
      .alu_res   (alu_res),
      .flags     (flags),
      .pc        (pc)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0]  m_mem [256];
   logic [31:0] m_im  [256];
   logic [7:0]  m_pc, m_res;
   logic [3:0]  m_fl;

   function automatic int sx(logic [7:0] v);
      return v[7] ? int'(v) - 256 : int'(v);
   endfunction

   task automatic model_exec();
      logic [7:0] op, x, y, z, a, b, r, npc;
      int sa, sb, sr;
      bit ov, alu, tk;
      op = m_im[m_pc][31:24];
      x  = m_im[m_pc][23:16];
      y  = m_im[m_pc][15:8];
      z  = m_im[m_pc][7:0];
      npc = m_pc + 8'd1;
      alu = 1'b0; ov = 1'b0; r = 8'h00; tk = 1'b0;
      case (op)
         8'h40, 8'hC0, 8'h00, 8'h20, 8'hE0,
         8'h44, 8'hC4, 8'h04, 8'h24, 8'hE4: begin
            alu = 1'b1;
            a  = m_mem[x];
            b  = op[2] ? y : m_mem[y];
            sa = sx(a); sb = sx(b);
            case (op & 8'hFB)
               8'h40: begin sr = sa + sb; r = a + b; ov = (sr > 127) || (sr < -128); end
               8'hC0: begin sr = sa - sb; r = a - b; ov = (sr > 127) || (sr < -128); end
               8'h00: r = a & b;
               8'h20: r = a | b;
               default: r = (sa < sb) ? 8'd1 : 8'd0;
            endcase
         end
         8'h05: m_mem[y] = x;
         8'h02: tk = m_fl[0];
         8'h0A: tk = m_fl[1];
         8'h12: tk = m_fl[2];
         8'h1A: tk = m_fl[3];
         8'h03: tk = 1'b1;
         default: ;
      endcase
      if (alu) begin
         m_mem[z] = r;
         m_res    = r;
         m_fl     = {ov, (r != 0) && !r[7], r[7], r == 0};
      end
      if (tk) npc = m_pc + x + 8'd1;
      m_pc = npc;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_res = 0; m_fl = 0;
         for (int i = 0; i < 256; i++) m_mem[i] = 0;
      end else if (!start) begin
         m_pc = 0;
         if (imem_wr) m_im[imem_addr] = imem_data;
      end else begin
         model_exec();
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare with the model on every cycle out of reset
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         chk(pc == m_pc,       "R7 model pc",      pc,      m_pc);
         chk(flags == m_fl,    "R5 model flags",   flags,   m_fl);
         chk(alu_res == m_res, "R2 model alu_res", alu_res, m_res);
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [31:0] prog_a(int i);
      case (i)
         0:   return 32'h050900FF;
         1:   return 32'h05120100;
         2:   return 32'h40000104;
         3:   return 32'h057F0200;
         4:   return 32'h44020105;
         5:   return 32'h05000300;
         6:   return 32'hC0000106;
         7:   return 32'hC4000907;
         8:   return 32'hC4000A08;
         9:   return 32'hE0060009;
         10:  return 32'hE400F70A;
         11:  return 32'h0004050B;
         12:  return 32'h2004050C;
         13:  return 32'h2404000D;
         14:  return 32'h8004050E;
         15:  return 32'h12020000;
         16:  return 32'h2404EE0F;
         17:  return 32'h2404EE0F;
         18:  return 32'h02050000;
         19:  return 32'h03EB0000;
         255: return 32'h03050000;
         default: return 32'h80000000;
      endcase
   endfunction

   function automatic logic [31:0] prog_b(int i);
      case (i)
         0: return 32'h24FF0010;
         1: return 32'h24010011;
         default: return 32'h80000000;
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_rf(string req, logic [7:0] r, logic [3:0] f);
      chk(alu_res == r, req, alu_res, r);
      chk(flags == f,   req, flags,   f);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; imem_wr = 1'b0;
      imem_addr = '0; imem_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(pc == 0,      "R1 reset pc",    pc,      0);
      chk(flags == 0,   "R1 reset flags", flags,   0);
      chk(alu_res == 0, "R1 reset res",   alu_res, 0);

      for (int i = 0; i < 256; i++) begin
         imem_wr = 1'b1; imem_addr = 8'(i); imem_data = prog_a(i);
         tick();
      end
      imem_wr = 1'b0;
      chk(pc == 0, "R9 pc held while loading", pc, 0);

      start = 1'b1;
      tick(); chk(pc == 1, "R9 first word from 00h", pc, 1);
      tick();
      tick(); expect_rf("R2 add 09h+12h", 8'h1B, 4'h4);
      tick();
      tick(); expect_rf("R5 addi overflow 7Fh+1", 8'h80, 4'hA);
      tick(); expect_rf("R6 load keeps res and flags", 8'h80, 4'hA);
      tick(); expect_rf("R2 sub 09h-12h", 8'hF7, 4'h2);
      tick(); expect_rf("R3 subi to zero", 8'h00, 4'h1);
      tick(); expect_rf("R3 subi operand order", 8'hFF, 4'h2);
      tick(); expect_rf("R4 slt signed true", 8'h01, 4'h4);
      tick(); expect_rf("R4 slti signed false", 8'h00, 4'h1);
      tick(); expect_rf("R2 and", 8'h00, 4'h1);
      tick(); expect_rf("R2 or", 8'h9B, 4'h2);
      tick(); expect_rf("R3 ori reads stored sum", 8'h1B, 4'h4);
      tick(); expect_rf("R11 undefined ALU code", 8'h1B, 4'h4);
      chk(pc == 15, "R11 undefined advances pc", pc, 15);
      tick(); chk(pc == 18, "R7 positive branch taken", pc, 18);
      tick(); chk(pc == 19, "R7 zero branch not taken", pc, 19);
      tick(); chk(pc == 255, "R8 unconditional branch", pc, 255);
      tick(); chk(pc == 5, "R8 pc wraps past FFh", pc, 5);

      start = 1'b0;
      tick(); chk(pc == 0, "R9 halt returns pc to 0", pc, 0);
      for (int i = 0; i < 256; i++) begin
         imem_wr = 1'b1; imem_addr = 8'(i); imem_data = prog_b(i);
         tick();
      end
      imem_wr = 1'b0;
      expect_rf("R9 nothing executes while halted", 8'h1B, 4'h4);
      chk(pc == 0, "R9 pc parked", pc, 0);

      start = 1'b1;
      tick(); expect_rf("R6 load low byte ignored, R1 store cleared", 8'h00, 4'h1);
      tick(); expect_rf("R6 load stored 12h at 01h", 8'h12, 4'h4);
      imem_wr = 1'b1; imem_addr = 8'h03; imem_data = 32'h24040000;
      tick();
      imem_wr = 1'b0;
      tick(); expect_rf("R10 write refused while running", 8'h12, 4'h4);
      chk(pc == 4, "R10 pc after refused write", pc, 4);

      repeat (300) tick();
      chk(pc == 8'(4 + 300), "R8 free run wraps", pc, 8'(4 + 300));
      finish_run();
   end
endmodule